// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block derives an SPI serial clock from a faster reference clock. The division ratio comes from an 8-bit prescale field that sits in an interface configuration register. A mode input chooses how the field is read. In the legacy reading, the low five bits select an even divisor from 4 to 30. In the extended reading, a 4-bit scaler is shifted left by a 3-bit power-of-two exponent. The exponent's bits are spread across field bits 4, 6 and 7, and they skip bit 5, which belongs to a different register function.

Alongside the serial clock, the block gives two one-cycle strobes. One marks each move of the clock away from its idle level, and the other marks each return to idle. A shift register outside this block uses them to launch and capture data. The idle level follows a polarity input. A change to the prescale field only shapes an active half-period that starts after the change, so no shortened pulse can appear on the serial clock.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: While reset is asserted (`rst_n` low), `sclk` equals `cpol`, and both `lead_stb` and `trail_stb` are low.
- R2: In legacy mode (`ext_mode` = 0), a value v in `prescale[4:0]` from 0x12 to 0x1F gives divisor 2·(v − 0x10), which is 4 to 30. `prescale[7:5]` has no effect.
- R3: In legacy mode, a value of `prescale[4:0]` below 0x12 gives divisor 4.
- R4: In extended mode (`ext_mode` = 1), the scaler is `prescale[3:0]` and the exponent is {`prescale[7]`, `prescale[6]`, `prescale[4]`}, most significant bit first. The divisor is scaler × 2^exponent, up to 1920.
- R5: In extended mode, `prescale[5]` has no effect on the divisor.
- R6: In extended mode, a nonzero scaler whose product is below 4 gives divisor 4.
- R7: In extended mode, a scaler of 0 holds `sclk` at its idle level and suppresses both strobes. Writing a nonzero scaler restarts the clock.
- R8: For divisor d, `sclk` spends floor(d/2) reference cycles away from idle, then d − floor(d/2) cycles at idle.
- R9: `lead_stb` is high for exactly the first reference cycle of each active half. `trail_stb` is high for exactly the first cycle of each idle half that follows an active half. The two strobes are never high together.
- R10: When `enable` falls during an active half, that half runs to its full length. `sclk` then stays idle with no strobes.
- R11: A prescale change made during an active half leaves that half's length unchanged. The new divisor governs the periods that follow.
- R12: The idle level of `sclk` equals `cpol`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the serial clock |
| ext_mode | input | 1 | 1 = extended prescale reading, 0 = legacy |
| prescale | input | 8 | Prescale field of the configuration register |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe on the move away from idle |
| trail_stb | output | 1 | One-cycle strobe on the return to idle |

## Verification
The assertions assume that `cpol` changes only while reset is held. `sclk` is derived from `cpol`, so moving the polarity during operation would look like a spurious clock edge. The stimulus therefore sets the polarity only inside a reset pulse. Prescale and enable changes are free at any cycle, and the bench deliberately makes them in the middle of an active half. Each period is measured only after one full period has passed on the new setting, so a measurement never straddles two divisors.

// File: rtl/spi_sclk_prescaler.sv
module spi_sclk_prescaler #(
  parameter int CW = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       ext_mode,
  input  logic [7:0] prescale,
  input  logic       cpol,
  output logic       sclk,
  output logic       lead_stb,
  output logic       trail_stb
);
  localparam logic [CW-1:0] MIN_DIV = CW'(4);

  logic [3:0]    spr;
  logic [2:0]    sppr;
  logic [CW-1:0] leg_div, ext_raw, ext_div, new_div, lo_len, hi_len;
  logic [CW-1:0] div_q, cnt;
  logic          cfg_ok, act;

  assign spr     = prescale[3:0];
  assign sppr    = {prescale[7:6], prescale[4]};
  assign leg_div = (prescale[4] && prescale[3:0] >= 4'd2) ? CW'({prescale[3:0], 1'b0}) : MIN_DIV;
  assign ext_raw = CW'(spr) << sppr;
  assign ext_div = (ext_raw < MIN_DIV) ? MIN_DIV : ext_raw;
  assign new_div = ext_mode ? ext_div : leg_div;
  assign cfg_ok  = !ext_mode || (spr != 4'd0);
  assign lo_len  = new_div - (new_div >> 1);
  assign hi_len  = div_q >> 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act       <= 1'b0;
      cnt       <= '0;
      div_q     <= MIN_DIV;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else begin
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
      if (!act) begin
        div_q <= new_div;
        if (enable && cfg_ok) begin
          if (cnt >= lo_len - CW'(1)) begin
            act      <= 1'b1;
            cnt      <= '0;
            lead_stb <= 1'b1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end else begin
          cnt <= '0;
        end
      end else begin
        if (cnt >= hi_len - CW'(1)) begin
          act       <= 1'b0;
          cnt       <= '0;
          trail_stb <= 1'b1;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  assign sclk = act ^ cpol;
endmodule

// File: rtl/spi_sclk_prescaler_chk.sv
module spi_sclk_prescaler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       ext_mode,
  input logic [7:0] prescale,
  input logic       cpol,
  input logic       sclk,
  input logic       lead_stb,
  input logic       trail_stb
);
  logic        act;
  logic [11:0] run;
  assign act = sclk ^ cpol;

  always_ff @(posedge clk) begin
    if (!rst_n)   run <= '0;
    else if (act) run <= run + 12'd1;
    else          run <= '0;
  end

  // R9
  lead_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(act) |-> lead_stb);
  // R9
  trail_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(act) |-> trail_stb);
  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(lead_stb && trail_stb));
  // R9
  lead_needs_act_chk: assert property (@(posedge clk) disable iff (!rst_n) lead_stb |-> act);
  // R10
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n) (!act && !enable) |=> !act);
  // R7
  zero_scaler_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && ext_mode && prescale[3:0] == 4'd0) |=> !act);
  // R4
  active_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) run <= 12'd960);
endmodule

bind spi_sclk_prescaler spi_sclk_prescaler_chk chk_i (.*);

// File: tb/spi_sclk_prescaler_tb.sv
module spi_sclk_prescaler_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, ext_mode = 1'b0, cpol = 1'b0;
  logic [7:0] prescale = 8'h12;
  logic sclk, lead_stb, trail_stb;
  int n_run = 0, n_fail = 0, wd = 0;

  always #2 clk = ~clk;

  spi_sclk_prescaler dut_i (.*);

  // {ext_mode, prescale, hi, lo}
  localparam int NV = 12;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 8'h12, 10'd2,   10'd2},
    {1'b0, 8'h1F, 10'd15,  10'd15},
    {1'b0, 8'hF5, 10'd5,   10'd5},
    {1'b0, 8'h05, 10'd2,   10'd2},
    {1'b1, 8'h03, 10'd2,   10'd2},
    {1'b1, 8'h05, 10'd2,   10'd3},
    {1'b1, 8'h13, 10'd3,   10'd3},
    {1'b1, 8'h37, 10'd7,   10'd7},
    {1'b1, 8'h47, 10'd14,  10'd14},
    {1'b1, 8'h8B, 10'd88,  10'd88},
    {1'b1, 8'hDF, 10'd960, 10'd960},
    {1'b1, 8'h01, 10'd2,   10'd2}
  };
  localparam string VTAG [NV] = '{"R2", "R2", "R2", "R3", "R6", "R8", "R4", "R5",
                                   "R4", "R4", "R4", "R6"};

  task automatic chk(input bit ok, input string tag, input int actual, input int expect_v);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expect_v);
    end
  endtask

  task automatic wait_lead();
    int n = 0;
    do begin @(negedge clk); n++; end while (!lead_stb && n < 5000);
  endtask

  task automatic measure(input int ehi, input int elo, input string tag);
    int hi = 0, lo = 0;
    wait_lead();
    wait_lead();
    while (sclk != cpol && hi < 5000) begin hi++; @(negedge clk); end
    chk(trail_stb == 1'b1, {tag, "/R9 trail"}, int'(trail_stb), 1);
    while (!lead_stb && lo < 5000) begin lo++; @(negedge clk); end
    chk(hi == ehi, {tag, "/R8 active"}, hi, ehi);
    chk(lo == elo, {tag, "/R8 idle"}, lo, elo);
  endtask

  task automatic do_reset(input logic pol);
    @(negedge clk);
    rst_n = 1'b0; cpol = pol;
    repeat (3) @(negedge clk);
    chk(sclk == pol, "R1/R12 sclk in reset", int'(sclk), int'(pol));
    chk(!lead_stb && !trail_stb, "R1 strobes in reset", int'({lead_stb, trail_stb}), 0);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 190000);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int bad, n;
    do_reset(1'b0);
    enable = 1'b1;
    foreach (VEC[i]) begin
      ext_mode = VEC[i][28];
      prescale = VEC[i][27:20];
      measure(int'(VEC[i][19:10]), int'(VEC[i][9:0]), VTAG[i]);
    end

    // R12: inverted idle level
    do_reset(1'b1);
    enable = 1'b1; ext_mode = 1'b0; prescale = 8'h15;
    measure(5, 5, "R12");
    @(negedge clk);
    chk(sclk == 1'b1 || lead_stb == 1'b0, "R12 idle high", int'(sclk), 1);
    do_reset(1'b0);

    // R11: change during an active half
    enable = 1'b1; ext_mode = 1'b0; prescale = 8'h1F;
    wait_lead(); wait_lead();
    repeat (3) @(negedge clk);
    prescale = 8'h12;
    n = 0;
    while (sclk != cpol && n < 5000) begin n++; @(negedge clk); end
    chk(n == 12, "R11 active half kept", n, 12);
    measure(2, 2, "R11");

    // R10: disable mid-active
    prescale = 8'h1F;
    wait_lead(); wait_lead();
    @(negedge clk);
    enable = 1'b0;
    n = 0;
    while (sclk != cpol && n < 5000) begin n++; @(negedge clk); end
    chk(n == 14, "R10 active half completes", n, 14);
    bad = 0;
    repeat (200) begin @(negedge clk); if (sclk != cpol || lead_stb || trail_stb) bad++; end
    chk(bad == 0, "R10 idle while disabled", bad, 0);

    // R7: zero scaler
    ext_mode = 1'b1; prescale = 8'hC0; enable = 1'b1;
    bad = 0;
    repeat (200) begin @(negedge clk); if (sclk != cpol || lead_stb || trail_stb) bad++; end
    chk(bad == 0, "R7 zero scaler idle", bad, 0);
    prescale = 8'h05;
    measure(2, 3, "R7 restart");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule